// File: doc/BRIEF.md
# Method-Channel FIFO Portal

This block connects a host register bus to a set of independent message channels. Each channel is a one-way FIFO of 32-bit argument words. Request channels carry messages from the host to the local logic. Indication channels carry messages from the local logic back to the host. Each channel has a fixed number of words per message. A consumer never sees a partial message: words become visible only after the final word of their message has been stored.

One bus slave serves every channel. The upper address bits choose a 4 KiB window, and a small offset inside that window chooses either the data word or the status word of that channel. One extra control window holds two registers:
- a pending-method register, which names the lowest-numbered indication channel holding a complete message;
- an interrupt-enable bit.

The interrupt output stays high while the enable bit is set and any indication channel holds a complete message.

A small bus-response state machine handles the bus. It has two states:
- `ST_IDLE`: bus accepted, `bus_ready` high.
- `ST_READ_RESP`: read data presented, `bus_ready` low.

It has two transitions:
- `read_accept` (from `ST_IDLE` to `ST_READ_RESP` when a read is accepted).
- `resp_done` (from `ST_READ_RESP` back to `ST_IDLE` unconditionally, one cycle later).

Writes finish in `ST_IDLE` in a single cycle.

Top module: `mmio_method_portal`

## Requirements
- R1: Address map. `bus_addr[15:12]` selects the window. Windows 0 and 1 are request channels 0 and 1. Windows 2 and 3 are indication channels 0 and 1. Window 4 is control. Within a channel window, offset 0x000 is the data word and 0x004 is the status word. In the control window, 0x000 is the pending-method register and 0x004 is the interrupt enable (bit 0, read/write). Writes to an indication window have no effect. Reads of unmapped locations and of request data return zero.
- R2: Request framing. Request channel 0 carries 2 words per message and channel 1 carries 3. `req_valid[i]` rises only once a complete message has been written. `req_data` then shows the words in write order, and `req_pop[i]` consumes one word.
- R3: Indication framing. Indication channel 0 carries 1 word per message and channel 1 carries 2. Words pushed by the logic become readable by the host, and count as pending, only once their message is complete. A host read of the data word pops one word.
- R4: Overflow. Each channel holds 8 words. A host write to a full request channel is dropped. A logic push while `ind_full[j]` is high is dropped.
- R5: Underflow. A host read of an indication data word with no complete message returns zero and removes nothing. `req_pop` with `req_valid` low has no effect.
- R6: The pending-method register returns the lowest indication index with a complete message, or 0xFFFFFFFF when none is pending.
- R7: `irq` is high exactly when the enable bit is set and at least one indication channel holds a complete message.
- R8: Traffic on one channel never alters the contents or status of any other channel.
- R9: Status word bits: bit 0 = full (8 words stored), bit 1 = empty (no words stored), bit 2 = a complete message is held. All other bits are zero.
- R10: Bus timing. Read data appears with `bus_rvalid` high in the cycle after the read is accepted. During that cycle `bus_ready` is low. `bus_rvalid` is a one-cycle pulse.
- R11: After reset, every channel is empty, the enable bit is 0, `irq` is low, and the pending register reads 0xFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Bus request present |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Byte address within the portal |
| bus_wdata | input | 32 | Write data |
| bus_ready | output | 1 | Portal accepts a request this cycle |
| bus_rvalid | output | 1 | Read data valid |
| bus_rdata | output | 32 | Read data |
| req_valid | output | 2 | Request channel holds a complete-message word |
| req_data | output | 64 | Head word of each request channel, 32 bits per channel |
| req_pop | input | 2 | Logic consumes one request word |
| ind_push | input | 2 | Logic stores one indication word |
| ind_data | input | 64 | Indication words, 32 bits per channel |
| ind_full | output | 2 | Indication channel is full |
| irq | output | 1 | Interrupt to host |

## Verification
The assertions check the following on every cycle:
- Word counts never exceed the depth.
- The committed words never exceed the stored words.
- Pushes into a full channel and pops of an empty channel leave the count untouched.
- Each accepted read is followed by a one-cycle response during which the bus is held off.
- The interrupt never rises without its enable.
- The pending register reads all-ones only when nothing is pending.

Only the bench's scenarios can show the remaining behaviours. These are word ordering, delivery of exactly whole messages, the lowest-index choice among several pending channels, the status encodings, and the independence of neighbouring channels. The bench shows them by comparing against a queue model on every clock.

// File: rtl/portal_pkg.sv
package portal_pkg;

    typedef enum logic [0:0] {
        ST_IDLE,
        ST_READ_RESP
    } bus_state_e;

    typedef enum logic [1:0] {
        WIN_REQ,
        WIN_IND,
        WIN_CTRL,
        WIN_NONE
    } win_kind_e;

    localparam logic [11:0] OFS_DATA = 12'h000;
    localparam logic [11:0] OFS_STAT = 12'h004;

    localparam int STAT_FULL_BIT  = 0;
    localparam int STAT_EMPTY_BIT = 1;
    localparam int STAT_MSG_BIT   = 2;

    function automatic logic [31:0] status_word(input logic full, input logic empty,
                                                input logic msg);
        logic [31:0] w;
        w = '0;
        w[STAT_FULL_BIT]  = full;
        w[STAT_EMPTY_BIT] = empty;
        w[STAT_MSG_BIT]   = msg;
        return w;
    endfunction

endpackage

// File: rtl/method_fifo.sv
module method_fifo #(
    parameter int DEPTH = 8,
    parameter int LEN   = 2,
    parameter int DW    = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] pop_data,
    output logic          full,
    output logic          empty,
    output logic          avail
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int FW = $clog2(LEN + 1);

    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wptr, rptr;
    logic [CW-1:0] cnt, com;
    logic [FW-1:0] frag;
    logic          do_push, do_pop, last_word;

    assign full      = (cnt == CW'(DEPTH));
    assign empty     = (cnt == '0);
    assign avail     = (com != '0);
    assign do_push   = push && !full;
    assign do_pop    = pop && avail;
    assign last_word = (frag == FW'(LEN - 1));
    assign pop_data  = mem[rptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
            cnt  <= '0;
            com  <= '0;
            frag <= '0;
        end else begin
            if (do_push) begin
                wptr <= wptr + 1'b1;
                frag <= last_word ? '0 : frag + 1'b1;
            end
            if (do_pop) rptr <= rptr + 1'b1;
            cnt <= cnt + CW'(do_push) - CW'(do_pop);
            com <= com + ((do_push && last_word) ? CW'(LEN) : '0) - CW'(do_pop);
        end
    end

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH));

    // R2
    commit_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        com <= cnt);

    // R4
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> (cnt == $past(cnt)));

    // R5
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !avail && !push) |=> (cnt == $past(cnt)));

endmodule

// File: rtl/mmio_method_portal.sv
module mmio_method_portal
    import portal_pkg::*;
#(
    parameter int                   N_REQ   = 2,
    parameter int                   N_IND   = 2,
    parameter int                   DEPTH   = 8,
    parameter int                   ADDR_W  = 16,
    parameter logic [N_REQ*8-1:0]   REQ_LEN = {8'd3, 8'd2},
    parameter logic [N_IND*8-1:0]   IND_LEN = {8'd2, 8'd1}
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_valid,
    input  logic                 bus_write,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic                 bus_ready,
    output logic                 bus_rvalid,
    output logic [31:0]          bus_rdata,
    output logic [N_REQ-1:0]     req_valid,
    output logic [N_REQ*32-1:0]  req_data,
    input  logic [N_REQ-1:0]     req_pop,
    input  logic [N_IND-1:0]     ind_push,
    input  logic [N_IND*32-1:0]  ind_data,
    output logic [N_IND-1:0]     ind_full,
    output logic                 irq
);
    localparam int WIN_W  = ADDR_W - 12;
    localparam int N_WIN  = N_REQ + N_IND;

    bus_state_e state_q, state_d;
    win_kind_e  kind;
    int         idx;
    logic [WIN_W-1:0] win;
    logic [11:0]      ofs;
    logic             rd_acc, wr_acc;
    logic             irq_en_q;
    logic [31:0]      rd_word, rdata_q, pend_word;

    logic [N_REQ-1:0] req_push, req_full, req_empty;
    logic [N_IND-1:0] ind_pop, ind_empty, ind_avail;
    logic [31:0]      ind_rd [N_IND];

    assign win    = bus_addr[ADDR_W-1:12];
    assign ofs    = bus_addr[11:0];
    assign rd_acc = bus_valid && bus_ready && !bus_write;
    assign wr_acc = bus_valid && bus_ready && bus_write;

    // window decode
    always_comb begin
        kind = WIN_NONE;
        idx  = 0;
        if (int'(win) < N_REQ) begin
            kind = WIN_REQ;
            idx  = int'(win);
        end else if (int'(win) < N_WIN) begin
            kind = WIN_IND;
            idx  = int'(win) - N_REQ;
        end else if (int'(win) == N_WIN) begin
            kind = WIN_CTRL;
        end
    end

    // per-channel strobes
    always_comb begin
        for (int i = 0; i < N_REQ; i++)
            req_push[i] = wr_acc && (kind == WIN_REQ) && (idx == i) && (ofs == OFS_DATA);
        for (int j = 0; j < N_IND; j++)
            ind_pop[j] = rd_acc && (kind == WIN_IND) && (idx == j) && (ofs == OFS_DATA);
    end

    // pending-method encoder: lowest index wins
    always_comb begin
        pend_word = '1;
        for (int j = N_IND - 1; j >= 0; j--)
            if (ind_avail[j]) pend_word = 32'(j);
    end

    // read multiplexer
    always_comb begin
        rd_word = '0;
        case (kind)
            WIN_REQ: begin
                for (int i = 0; i < N_REQ; i++)
                    if (idx == i && ofs == OFS_STAT)
                        rd_word = status_word(req_full[i], req_empty[i], req_valid[i]);
            end
            WIN_IND: begin
                for (int j = 0; j < N_IND; j++) begin
                    if (idx == j && ofs == OFS_STAT)
                        rd_word = status_word(ind_full[j], ind_empty[j], ind_avail[j]);
                    else if (idx == j && ofs == OFS_DATA && ind_avail[j])
                        rd_word = ind_rd[j];
                end
            end
            WIN_CTRL: begin
                if (ofs == OFS_DATA)      rd_word = pend_word;
                else if (ofs == OFS_STAT) rd_word = {31'b0, irq_en_q};
            end
            default: rd_word = '0;
        endcase
    end

    // bus-response state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (rd_acc) state_d = ST_READ_RESP;
            ST_READ_RESP: state_d = ST_IDLE;
        endcase
    end

    // outputs of the state machine
    always_comb begin
        bus_ready  = (state_q == ST_IDLE);
        bus_rvalid = (state_q == ST_READ_RESP);
        bus_rdata  = rdata_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q  <= '0;
            irq_en_q <= 1'b0;
        end else begin
            if (rd_acc) rdata_q <= rd_word;
            if (wr_acc && kind == WIN_CTRL && ofs == OFS_STAT) irq_en_q <= bus_wdata[0];
        end
    end

    assign irq = irq_en_q && (|ind_avail);

    generate
        for (genvar gi = 0; gi < N_REQ; gi++) begin : g_req
            method_fifo #(
                .DEPTH (DEPTH),
                .LEN   (int'(REQ_LEN[gi*8 +: 8])),
                .DW    (32)
            ) u_fifo (
                .clk       (clk),
                .rst_n     (rst_n),
                .push      (req_push[gi]),
                .push_data (bus_wdata),
                .pop       (req_pop[gi]),
                .pop_data  (req_data[gi*32 +: 32]),
                .full      (req_full[gi]),
                .empty     (req_empty[gi]),
                .avail     (req_valid[gi])
            );
        end
        for (genvar gj = 0; gj < N_IND; gj++) begin : g_ind
            method_fifo #(
                .DEPTH (DEPTH),
                .LEN   (int'(IND_LEN[gj*8 +: 8])),
                .DW    (32)
            ) u_fifo (
                .clk       (clk),
                .rst_n     (rst_n),
                .push      (ind_push[gj]),
                .push_data (ind_data[gj*32 +: 32]),
                .pop       (ind_pop[gj]),
                .pop_data  (ind_rd[gj]),
                .full      (ind_full[gj]),
                .empty     (ind_empty[gj]),
                .avail     (ind_avail[gj])
            );
        end
    endgenerate

    // R10
    read_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_ready && !bus_write) |=> (bus_rvalid && !bus_ready));

    // R10
    rvalid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid |=> !bus_rvalid);

    // R7
    irq_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> irq_en_q);

    // R6
    pending_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_word == '1) |-> !(|ind_avail));

endmodule

// File: tb/mmio_method_portal_bench.sv
module mmio_method_portal_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0, bus_write = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_ready, bus_rvalid, irq;
    logic [31:0] bus_rdata;
    logic [1:0]  req_valid, ind_full;
    logic [63:0] req_data;
    logic [1:0]  req_pop = '0, ind_push = '0;
    logic [63:0] ind_data = '0;

    int checks = 0, fails = 0;
    bit done = 0, mon_on = 0;

    // reference model: channels 0,1 request; 2,3 indication
    logic [31:0] m_mem [4][8];
    int m_size [4] = '{0, 0, 0, 0};
    int m_frag [4] = '{0, 0, 0, 0};
    int m_com  [4] = '{0, 0, 0, 0};
    int m_len  [4] = '{2, 3, 1, 2};
    bit m_en = 0;

    always #4 clk = ~clk;

    mmio_method_portal u_mmio_method_portal (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
        .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata), .req_valid(req_valid),
        .req_data(req_data), .req_pop(req_pop), .ind_push(ind_push),
        .ind_data(ind_data), .ind_full(ind_full), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic m_push(input int f, input logic [31:0] d);
        if (m_size[f] < 8) begin
            m_mem[f][m_size[f]] = d;
            m_size[f]++;
            if (m_frag[f] == m_len[f] - 1) begin
                m_frag[f] = 0;
                m_com[f] += m_len[f];
            end else m_frag[f]++;
        end
    endtask

    function automatic logic [31:0] m_pop(input int f);
        logic [31:0] d;
        if (m_com[f] == 0) return 32'h0;
        d = m_mem[f][0];
        for (int k = 0; k < 7; k++) m_mem[f][k] = m_mem[f][k+1];
        m_size[f]--;
        m_com[f]--;
        return d;
    endfunction

    function automatic logic [31:0] m_stat(input int f);
        return {29'b0, m_com[f] > 0, m_size[f] == 0, m_size[f] == 8};
    endfunction

    function automatic logic [31:0] m_pending();
        if (m_com[2] > 0) return 32'd0;
        if (m_com[3] > 0) return 32'd1;
        return 32'hFFFF_FFFF;
    endfunction

    function automatic logic [31:0] m_read(input logic [15:0] a);
        int w;
        logic [11:0] o;
        w = int'(a[15:12]);
        o = a[11:0];
        if (w < 2)  return (o == 12'h004) ? m_stat(w) : 32'h0;
        if (w < 4) begin
            if (o == 12'h000) return m_pop(w);
            if (o == 12'h004) return m_stat(w);
            return 32'h0;
        end
        if (w == 4) begin
            if (o == 12'h000) return m_pending();
            if (o == 12'h004) return {31'b0, m_en};
        end
        return 32'h0;
    endfunction

    task automatic bus_wr(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        if (a[15:12] < 4'd2 && a[11:0] == 12'h000) m_push(int'(a[15:12]), d);
        if (a[15:12] == 4'd4 && a[11:0] == 12'h004) m_en = d[0];
        bus_valid = 0; bus_write = 0;
    endtask

    task automatic bus_rd(input string tag, input logic [15:0] a);
        logic [31:0] exp;
        @(negedge clk);
        bus_valid = 1; bus_write = 0; bus_addr = a;
        @(posedge clk); #1;
        exp = m_read(a);
        bus_valid = 0;
        @(negedge clk);
        chk({tag, " R10 rvalid"}, {31'b0, bus_rvalid}, 32'd1);
        chk({tag, " R10 ready low"}, {31'b0, bus_ready}, 32'd0);
        chk(tag, bus_rdata, exp);
    endtask

    task automatic logic_pop(input int i);
        @(negedge clk);
        req_pop[i] = 1'b1;
        @(posedge clk); #1;
        void'(m_pop(i));
        req_pop[i] = 1'b0;
    endtask

    task automatic logic_push(input int j, input logic [31:0] d);
        @(negedge clk);
        ind_push[j] = 1'b1;
        ind_data[j*32 +: 32] = d;
        @(posedge clk); #1;
        m_push(2 + j, d);
        ind_push[j] = 1'b0;
    endtask

    // per-cycle comparison with the model
    always @(negedge clk) begin
        if (mon_on) begin
            chk("R7 irq", {31'b0, irq}, {31'b0, m_en && (m_com[2] > 0 || m_com[3] > 0)});
            for (int i = 0; i < 2; i++) begin
                chk("R2 req_valid", {31'b0, req_valid[i]}, {31'b0, m_com[i] > 0});
                if (m_com[i] > 0) chk("R2 req_data", req_data[i*32 +: 32], m_mem[i][0]);
                chk("R4 ind_full", {31'b0, ind_full[i]}, {31'b0, m_size[2+i] == 8});
            end
        end
    end

    initial begin
        repeat (30000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        mon_on = 1;

        // R11 reset state
        bus_rd("R11 pending after reset", 16'h4000);
        bus_rd("R11 enable after reset", 16'h4004);
        bus_rd("R11 R9 req0 status empty", 16'h0004);
        bus_rd("R11 ind1 status empty", 16'h3004);

        // R2 framing on request channel 0 (2 words)
        bus_wr(16'h0000, 32'hA000_0001);
        @(negedge clk); chk("R2 partial not visible", {31'b0, req_valid[0]}, 32'd0);
        bus_wr(16'h0000, 32'hA000_0002);
        @(negedge clk); chk("R2 complete visible", {31'b0, req_valid[0]}, 32'd1);
        chk("R2 head word", req_data[31:0], 32'hA000_0001);
        logic_pop(0);
        logic_pop(0);
        logic_pop(0); // R5 pop with nothing valid
        bus_rd("R5 req0 empty after extra pop", 16'h0004);

        // R8 independence: channel 1 (3 words) alongside channel 0
        bus_wr(16'h1000, 32'hB1);
        bus_wr(16'h1000, 32'hB2);
        bus_rd("R8 req0 untouched", 16'h0004);
        bus_wr(16'h1000, 32'hB3);
        @(negedge clk); chk("R8 req1 complete", {30'b0, req_valid}, 32'd2);
        bus_rd("R1 request data reads zero", 16'h1000);
        for (int k = 0; k < 3; k++) logic_pop(1);

        // R4 fill request channel 0 then overflow
        for (int k = 0; k < 9; k++) bus_wr(16'h0000, 32'hD0 + k);
        bus_rd("R4 R9 req0 full status", 16'h0004);
        for (int k = 0; k < 8; k++) logic_pop(0);
        bus_rd("R4 overflow word dropped", 16'h0004);

        // R3 indication framing and R5 reads without complete message
        logic_push(1, 32'hE1);
        bus_rd("R3 partial not pending", 16'h4000);
        bus_rd("R5 read partial returns zero", 16'h3000);
        bus_rd("R9 ind1 partial status", 16'h3004);
        logic_push(1, 32'hE2);
        bus_rd("R6 pending ind1", 16'h4000);
        @(negedge clk); chk("R7 irq disabled", {31'b0, irq}, 32'd0);
        bus_wr(16'h4004, 32'h1);
        @(negedge clk); chk("R7 irq enabled", {31'b0, irq}, 32'd1);
        logic_push(0, 32'hF0);
        bus_rd("R6 lowest index wins", 16'h4000);
        bus_rd("R3 ind0 word", 16'h2000);
        bus_rd("R6 pending back to ind1", 16'h4000);
        bus_rd("R3 ind1 word 0", 16'h3000);
        bus_rd("R3 ind1 word 1", 16'h3000);
        bus_rd("R6 none pending", 16'h4000);
        @(negedge clk); chk("R7 irq idle", {31'b0, irq}, 32'd0);
        bus_rd("R5 empty read zero", 16'h3000);

        // R1 writes to indication window ignored
        bus_wr(16'h2000, 32'h1234_5678);
        bus_rd("R1 ind0 still empty", 16'h2004);

        // R4 indication overflow
        for (int k = 0; k < 9; k++) logic_push(0, 32'hC0 + k);
        bus_rd("R4 ind0 full status", 16'h2004);
        for (int k = 0; k < 9; k++) bus_rd("R4 ind0 drain", 16'h2000);
        bus_rd("R1 unmapped window", 16'h7000);
        bus_rd("R1 enable readback", 16'h4004);

        mon_on = 0;
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule